// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the 16-bit arithmetic and logic unit behind a processor's two-operand instruction group. Each cycle it receives a source word, a destination word, a 4-bit operation code and the current status nibble. It returns the new destination value, a write-back enable, a status-update enable and the status nibble that the core should hold next. Operand fetch, addressing and byte-wide operation are handled elsewhere.

The operation set covers copy, add, add with carry, subtract, subtract with carry, compare, bit test, bit clear, bit set, exclusive OR and AND. The flag rules depend on the operation. Compare and bit test report flags but leave the destination alone. Copy, bit clear and bit set never touch the flags. The logic operations use carry to mean "the result was nonzero". Codes with no operation behind them are reported as unsupported, and decimal add is one of these.

The logic is purely combinational. A parameter selects whether all outputs pass through one register stage, which is the default.

Top module: `dualop_alu`

## Requirements
- R1: Operation codes are 4 = copy, 5 = add, 6 = add with carry, 7 = subtract with carry, 8 = subtract, 9 = compare, 11 = bit test, 12 = bit clear, 13 = bit set, 14 = XOR and 15 = AND. Copy drives the source onto `res` and raises `wr_en`.
- R2: Add returns dst + src. Add with carry also adds status bit 0 (C). In the status nibble bit 0 is C, bit 1 is Z, bit 2 is N and bit 3 is V. The new C is the carry out of bit 15 of the 17-bit sum.
- R3: Subtract returns dst + ~src + 1. Subtract with carry uses the incoming C in place of the 1. C is the carry out of bit 15, so it is 1 when no borrow occurs.
- R4: For the add forms, V is set when both operands share a sign and the result sign differs from it. For the subtract forms, V is set when the operand signs differ and the result sign differs from the destination sign.
- R5: Compare produces the same result and flags as subtract, with `wr_en` = 0 and `stat_upd` = 1.
- R6: For bit test (dst AND src), AND and XOR: N is result bit 15, Z is set on a zero result, and C = NOT Z. V is 0 for AND and bit test. For XOR, V is set when both operands have bit 15 set. Bit test does not write back.
- R7: Copy, bit clear (dst AND NOT src) and bit set (dst OR src) write back with `stat_upd` = 0 and `stat_out` equal to `stat_in`.
- R8: N and Z look only at the 16-bit result. A carry into bit 16 never counts as a nonzero result.
- R9: Codes 0 to 3 and 10 raise `unsup`, force `wr_en` and `stat_upd` to 0, drive `res` to 0 and pass `stat_in` through unchanged.
- R10: With the output register enabled, every output shows the inputs from the previous rising clock edge. While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| op | input | 4 | Operation code |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| stat_in | input | 4 | Current status {V,N,Z,C} |
| res | output | 16 | Result word |
| wr_en | output | 1 | Destination write-back enable |
| stat_upd | output | 1 | Status update enable |
| stat_out | output | 4 | Next status {V,N,Z,C} |
| unsup | output | 1 | Unsupported operation code |

## Verification
The block has no internal state apart from the output stage. A wrong decode or a wrong flag rule therefore shows on the very next registered output, one clock after the inputs are applied. A mistake in the carry-in or operand-inversion choice shows up as a result that is off by one or has the wrong sign. A mistake in the flag enables shows up as a status nibble that either moves when it should hold or holds when it should move. Because of this, the vectors pair each operation with a status input whose bits differ from the expected new flags, so that a missing update cannot go unseen.

// File: rtl/dualop_alu_pkg.sv
package dualop_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'd4,
    OP_ADD  = 4'd5,
    OP_ADDC = 4'd6,
    OP_SUBC = 4'd7,
    OP_SUB  = 4'd8,
    OP_CMP  = 4'd9,
    OP_DADD = 4'd10,
    OP_BIT  = 4'd11,
    OP_BIC  = 4'd12,
    OP_BIS  = 4'd13,
    OP_XOR  = 4'd14,
    OP_AND  = 4'd15
  } alu_op_e;

  // status nibble positions
  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_N = 2;
  localparam int ST_V = 3;
  localparam int ST_W = 4;
  localparam int OP_W = 4;
endpackage

// File: rtl/dualop_arith.sv
module dualop_arith
  import dualop_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  input  logic            cin,
  output logic [W-1:0]    sum,
  output logic            cout,
  output logic            ovf
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] wide_add(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic         ci);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic sign_flip(input logic a_msb, input logic b_msb,
                                     input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  logic         is_sub;
  logic         use_c;
  logic         ci_eff;
  logic [W-1:0] b_opnd;
  logic [W:0]   full;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    use_c  = (op == OP_ADDC) || (op == OP_SUBC);
    b_opnd = is_sub ? ~src : src;
    ci_eff = use_c ? cin : is_sub;
    full   = wide_add(dst, b_opnd, ci_eff);
    sum    = full[W-1:0];
    cout   = full[W];
    ovf    = sign_flip(dst[MSB], b_opnd[MSB], sum[MSB]);
  end
endmodule

// File: rtl/dualop_logic.sv
module dualop_logic
  import dualop_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  output logic [W-1:0]    lres,
  output logic            lovf
);
  localparam int MSB = W - 1;

  always_comb begin
    case (op)
      OP_MOV:  lres = src;
      OP_BIC:  lres = dst & ~src;
      OP_BIS:  lres = dst | src;
      OP_XOR:  lres = dst ^ src;
      default: lres = dst & src;
    endcase
    lovf = (op == OP_XOR) && dst[MSB] && src[MSB];
  end
endmodule

// File: rtl/dualop_outreg.sv
module dualop_outreg #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dualop_alu.sv
module dualop_alu
  import dualop_alu_pkg::*;
#(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  input  logic [ST_W-1:0] stat_in,
  output logic [W-1:0]    res,
  output logic            wr_en,
  output logic            stat_upd,
  output logic [ST_W-1:0] stat_out,
  output logic            unsup
);
  localparam int MSB = W - 1;
  localparam int DW  = W + ST_W + 3;

  // named internal events, observed by the checker
  logic [W-1:0]    ar_sum;
  logic            ar_c;
  logic            ar_v;
  logic [W-1:0]    lg_res;
  logic            lg_v;
  logic            is_arith;
  logic            is_logic;
  logic [W-1:0]    nxt_res;
  logic            nxt_wr;
  logic            nxt_upd;
  logic            nxt_unsup;
  logic [ST_W-1:0] nxt_stat;
  logic            f_n;
  logic            f_z;
  logic            f_c;
  logic            f_v;

  dualop_arith #(.W(W)) u_arith (
    .op(op), .src(src), .dst(dst), .cin(stat_in[ST_C]),
    .sum(ar_sum), .cout(ar_c), .ovf(ar_v)
  );

  dualop_logic #(.W(W)) u_logic (
    .op(op), .src(src), .dst(dst), .lres(lg_res), .lovf(lg_v)
  );

  always_comb begin
    is_arith  = (op >= OP_ADD) && (op <= OP_CMP);
    is_logic  = (op == OP_MOV) || (op >= OP_BIT);
    nxt_unsup = !(is_arith || is_logic);
    nxt_res   = nxt_unsup ? '0 : (is_arith ? ar_sum : lg_res);
    nxt_wr    = !nxt_unsup && (op != OP_CMP) && (op != OP_BIT);
    nxt_upd   = is_arith || (op == OP_BIT) || (op == OP_XOR) || (op == OP_AND);
    f_n       = nxt_res[MSB];
    f_z       = (nxt_res == '0);
    f_c       = is_arith ? ar_c : !f_z;
    f_v       = is_arith ? ar_v : lg_v;
    nxt_stat  = stat_in;
    if (nxt_upd) begin
      nxt_stat[ST_N] = f_n;
      nxt_stat[ST_Z] = f_z;
      nxt_stat[ST_C] = f_c;
      nxt_stat[ST_V] = f_v;
    end
  end

  dualop_outreg #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d({nxt_res, nxt_wr, nxt_upd, nxt_stat, nxt_unsup}),
    .q({res, wr_en, stat_upd, stat_out, unsup})
  );
endmodule

// File: rtl/dualop_alu_chk.sv
module dualop_alu_chk
  import dualop_alu_pkg::*;
#(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op,
  input logic [ST_W-1:0] stat_in,
  input logic [W-1:0]    nxt_res,
  input logic            nxt_wr,
  input logic            nxt_upd,
  input logic            nxt_unsup,
  input logic [ST_W-1:0] nxt_stat,
  input logic [W-1:0]    res,
  input logic            wr_en,
  input logic            stat_upd,
  input logic [ST_W-1:0] stat_out,
  input logic            unsup
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_unsup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_unsup |-> (!nxt_wr && !nxt_upd && nxt_res == '0));

  assert_hold_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_upd |-> (nxt_stat == stat_in));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (!nxt_wr && nxt_upd));

  assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND || op == OP_BIT || op == OP_XOR) |->
      (nxt_stat[ST_C] == !nxt_stat[ST_Z]));

  assert_and_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND || op == OP_BIT) |-> !nxt_stat[ST_V]);

  generate
    if (REG_OUT) begin : g_pipe
      assert_one_stage_R10: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (res == $past(nxt_res) && wr_en == $past(nxt_wr) &&
                    stat_upd == $past(nxt_upd) && stat_out == $past(nxt_stat) &&
                    unsup == $past(nxt_unsup)));
    end else begin : g_comb
      always_comb begin
        assert_one_stage_R10: assert (res == nxt_res && unsup == nxt_unsup &&
                                      wr_en == nxt_wr && stat_upd == nxt_upd &&
                                      stat_out == nxt_stat);
      end
    end
  endgenerate
endmodule

bind dualop_alu dualop_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .stat_in(stat_in),
  .nxt_res(nxt_res), .nxt_wr(nxt_wr), .nxt_upd(nxt_upd),
  .nxt_unsup(nxt_unsup), .nxt_stat(nxt_stat),
  .res(res), .wr_en(wr_en), .stat_upd(stat_upd),
  .stat_out(stat_out), .unsup(unsup)
);

// File: tb/test_dualop_alu.sv
module test_dualop_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] src = '0;
  logic [15:0] dst = '0;
  logic [3:0]  stat_in = '0;
  logic [15:0] res;
  logic        wr_en;
  logic        stat_upd;
  logic [3:0]  stat_out;
  logic        unsup;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  dualop_alu i_dualop_alu (
    .clk(clk), .rst_n(rst_n), .op(op), .src(src), .dst(dst),
    .stat_in(stat_in), .res(res), .wr_en(wr_en), .stat_upd(stat_upd),
    .stat_out(stat_out), .unsup(unsup)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] s;
    logic [15:0] d;
    logic [3:0]  st;
    logic [15:0] r;
    logic        wr;
    logic        upd;
    logic [3:0]  so;
    logic        un;
  } vec_t;

  localparam int NV = 18;
  // status nibble {V,N,Z,C}
  localparam vec_t VECS [NV] = '{
    '{4'd4,  16'h1234, 16'hABCD, 4'b0101, 16'h1234, 1'b1, 1'b0, 4'b0101, 1'b0}, // R1 R7 copy
    '{4'd5,  16'h7FFF, 16'h0001, 4'b0000, 16'h8000, 1'b1, 1'b1, 4'b1100, 1'b0}, // R2 R4 add overflow
    '{4'd5,  16'hFFFF, 16'h0001, 4'b0000, 16'h0000, 1'b1, 1'b1, 4'b0011, 1'b0}, // R2 R8 carry out, zero
    '{4'd6,  16'h0001, 16'h0001, 4'b0001, 16'h0003, 1'b1, 1'b1, 4'b0000, 1'b0}, // R2 add with carry
    '{4'd8,  16'h0001, 16'h0003, 4'b0000, 16'h0002, 1'b1, 1'b1, 4'b0001, 1'b0}, // R3 no borrow
    '{4'd8,  16'h0003, 16'h0001, 4'b0001, 16'hFFFE, 1'b1, 1'b1, 4'b0100, 1'b0}, // R3 borrow
    '{4'd8,  16'h0001, 16'h8000, 4'b0000, 16'h7FFF, 1'b1, 1'b1, 4'b1001, 1'b0}, // R4 sub overflow
    '{4'd7,  16'h0001, 16'h0003, 4'b0000, 16'h0001, 1'b1, 1'b1, 4'b0001, 1'b0}, // R3 subc C=0
    '{4'd9,  16'h0005, 16'h0005, 4'b0000, 16'h0000, 1'b0, 1'b1, 4'b0011, 1'b0}, // R5 compare equal
    '{4'd11, 16'h00F0, 16'h0F0F, 4'b1111, 16'h0000, 1'b0, 1'b1, 4'b0010, 1'b0}, // R6 bit test zero
    '{4'd15, 16'h8001, 16'h8003, 4'b1010, 16'h8001, 1'b1, 1'b1, 4'b0101, 1'b0}, // R6 and
    '{4'd14, 16'h8000, 16'h8001, 4'b0000, 16'h0001, 1'b1, 1'b1, 4'b1001, 1'b0}, // R6 xor both negative
    '{4'd12, 16'h00FF, 16'h1234, 4'b1010, 16'h1200, 1'b1, 1'b0, 4'b1010, 1'b0}, // R7 bit clear
    '{4'd13, 16'h00FF, 16'h1200, 4'b0110, 16'h12FF, 1'b1, 1'b0, 4'b0110, 1'b0}, // R7 bit set
    '{4'd10, 16'h0001, 16'h0001, 4'b0011, 16'h0000, 1'b0, 1'b0, 4'b0011, 1'b1}, // R9 decimal add
    '{4'd0,  16'hFFFF, 16'hFFFF, 4'b1000, 16'h0000, 1'b0, 1'b0, 4'b1000, 1'b1}, // R9 code 0
    '{4'd3,  16'h1111, 16'h2222, 4'b0101, 16'h0000, 1'b0, 1'b0, 4'b0101, 1'b1}, // R9 code 3
    '{4'd7,  16'h0000, 16'h0000, 4'b0001, 16'h0000, 1'b1, 1'b1, 4'b0011, 1'b0}  // R8 R3 subc carry into bit 16
  };

  function automatic string vec_tag(input logic [3:0] o);
    case (o)
      4'd4:           return "R1";
      4'd5, 4'd6:     return "R2";
      4'd7, 4'd8:     return "R3";
      4'd9:           return "R5";
      4'd11, 4'd14, 4'd15: return "R6";
      4'd12, 4'd13:   return "R7";
      default:        return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    op = v.op; src = v.s; dst = v.d; stat_in = v.st;
  endtask

  task automatic check_vec(input string tag, input vec_t v);
    check({tag, " res"},   {16'h0, res},       {16'h0, v.r});
    check({tag, " wr"},    {31'h0, wr_en},     {31'h0, v.wr});
    check({tag, " upd"},   {31'h0, stat_upd},  {31'h0, v.upd});
    check({tag, " stat"},  {28'h0, stat_out},  {28'h0, v.so});
    check({tag, " unsup"}, {31'h0, unsup},     {31'h0, v.un});
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: outputs cleared while in reset
    apply(VECS[1]);
    repeat (3) @(negedge clk);
    check("R10 reset res",  {16'h0, res}, 32'h0);
    check("R10 reset flags", {27'h0, wr_en, stat_upd, stat_out, unsup}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // table walk: drive at negedge, registered output valid at next negedge
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check_vec(vec_tag(VECS[i].op), VECS[i]);
    end

    // R10: one-stage latency; new inputs do not show before the edge
    apply(VECS[0]);
    @(negedge clk);
    apply(VECS[2]);
    #1;
    check("R10 latency hold", {16'h0, res}, {16'h0, VECS[0].r});
    @(negedge clk);
    check("R10 latency update", {16'h0, res}, {16'h0, VECS[2].r});

    // R8: 0xFFFF + 0xFFFF + carry gives nonzero low word with carry out
    op = 4'd6; src = 16'hFFFF; dst = 16'hFFFF; stat_in = 4'b0001;
    @(negedge clk);
    check("R8 addc max res", {16'h0, res}, 32'h0000FFFF);
    check("R8 addc max stat", {28'h0, stat_out}, 32'h5);

    // R4: add of two negatives into a positive sets V and C
    op = 4'd5; src = 16'h8000; dst = 16'h8000; stat_in = 4'b0000;
    @(negedge clk);
    check("R4 neg add stat", {28'h0, stat_out}, 32'hB);

    // R6: XOR with one negative operand leaves V clear, N set
    op = 4'd14; src = 16'h8000; dst = 16'h0001; stat_in = 4'b1000;
    @(negedge clk);
    check("R6 xor one neg stat", {28'h0, stat_out}, 32'h5);

    // R10: reset during operation clears outputs
    rst_n = 1'b0;
    #1;
    check("R10 async reset", {11'h0, res, wr_en, stat_upd, stat_out, unsup}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule